// File: doc/BRIEF.md
# Gate Interval Generator

This block times repeating acquisition windows for a bank of counters. A free-running reference tick (nominally 8 MHz, one cycle wide per tick) is divided into a base unit of 50 ms, from which a short window (50 ms or 100 ms) and a long window (500 ms or 1 s) are built. Both windows restart together whenever counting is enabled. At each window end the block pulses a transfer strobe that tells the counter bank to copy its counts into the read buffers. When the matching clear option is set, it follows that strobe with a clear strobe one cycle later.

A trailing edge on an external gate input can be used as a second source of transfer and clear strobes. The block keeps a sticky end flag for each window length, and software clears a flag by writing 0 to it. A combined interrupt line is raised for each flag whose own enable is set. The counters and the bus interface sit outside this block.

Top module: `gate_interval_gen`

## Requirements
- R1: After synchronous reset, `xfer_stb`, `clear_stb`, `short_flag`, `long_flag` and `irq` are all 0.
- R2: With `en` and `int_en` high, a short window lasts `UNIT_TICKS` reference ticks when `sel_50ms` is the only short select set, and twice that when `sel_100ms` is set. If both are set, the 100 ms length applies. Each short end pulses `xfer_stb` for one cycle.
- R3: A long window lasts 10 units when `sel_500ms` is the only long select set, and 20 units when `sel_1s` is set. If both are set, the 1 s length applies. Each long end pulses `xfer_stb`.
- R4: The unit, short and long counts are held at zero while `en` or `int_en` is low, and they all start from zero together. The first short end raises `xfer_stb` in the cycle after the clock edge that takes the UNIT_TICKS-th reference tick.
- R5: `clear_stb` pulses one cycle after a transfer pulse caused by a short end with `clr_on_short` set, or by a long end with `clr_on_long` set. No other internal end produces it.
- R6: With neither select of a window set, that window produces no strobe and no flag. With no select set at all, no internal strobe appears.
- R7: `short_flag` and `long_flag` set in the same cycle as the transfer of their window end and stay set. A cycle with `flag_wr` high clears each flag whose write bit (`flag_wr_short`, `flag_wr_long`) is 0. Writing 1 leaves the flag unchanged.
- R8: `irq` is high exactly when (`short_flag` and `ie_short`) or (`long_flag` and `ie_long`).
- R9: With `ext_en` high, a high-to-low transition of `ext_gate` gives one `xfer_stb` pulse on the third clock edge after the change (two synchroniser stages plus the edge register). A `clear_stb` pulse follows if either clear bit is set. A rising edge, or any edge while `ext_en` is low, gives no strobe.
- R10: Only cycles with `ref_tick` high advance the timing. With `ref_tick` held low, no internal strobe appears.
- R11: A long end always coincides with a short end when a short length is selected. In that cycle a single transfer pulse is produced and both flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference tick enable, one cycle per tick |
| ext_gate | input | 1 | Asynchronous external gate level |
| en | input | 1 | Master count enable |
| ext_en | input | 1 | External gate enable |
| int_en | input | 1 | Internal gate enable |
| sel_50ms | input | 1 | Short window 50 ms select |
| sel_100ms | input | 1 | Short window 100 ms select |
| sel_500ms | input | 1 | Long window 500 ms select |
| sel_1s | input | 1 | Long window 1 s select |
| clr_on_short | input | 1 | Clear counters at short end |
| clr_on_long | input | 1 | Clear counters at long end |
| ie_short | input | 1 | Short flag interrupt enable |
| ie_long | input | 1 | Long flag interrupt enable |
| flag_wr | input | 1 | Flag write strobe |
| flag_wr_short | input | 1 | Written value for short flag (0 clears) |
| flag_wr_long | input | 1 | Written value for long flag (0 clears) |
| xfer_stb | output | 1 | Buffer transfer strobe |
| clear_stb | output | 1 | Counter clear strobe |
| short_flag | output | 1 | Sticky short-window end flag |
| long_flag | output | 1 | Sticky long-window end flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the control inputs change only between clock edges and that `ref_tick` is a clean one-cycle enable. They also assume that `ext_gate` may be asynchronous, because only its synchronised copy is examined. The bench drives every input just after the falling clock edge. It changes the select and clear bits only while `en` is low, so a window length never changes mid-count. It holds `en` low while exercising the external gate, which keeps each strobe traceable to a single source. `UNIT_TICKS` is shrunk to 4 so that whole 1 s windows fit in a short run.

// File: rtl/gig_pkg.sv
package gig_pkg;

    typedef enum logic [1:0] {
        WIN_OFF   = 2'd0,
        WIN_SHORT = 2'd1,
        WIN_LONG  = 2'd2
    } win_len_e;

    localparam int UNIT_W = 5;

    typedef struct packed {
        logic short_end;
        logic long_end;
    } win_evt_t;

    typedef struct packed {
        logic xfer;
        logic clear;
    } strobe_t;

    // the longer of two selected lengths wins
    function automatic win_len_e pick_len(input logic sel_a, input logic sel_b);
        if (sel_b)      return WIN_LONG;
        else if (sel_a) return WIN_SHORT;
        else            return WIN_OFF;
    endfunction

    function automatic logic [UNIT_W-1:0] short_units(input win_len_e l);
        case (l)
            WIN_SHORT: return 5'd1;
            WIN_LONG:  return 5'd2;
            default:   return 5'd0;
        endcase
    endfunction

    function automatic logic [UNIT_W-1:0] long_units(input win_len_e l);
        case (l)
            WIN_SHORT: return 5'd10;
            WIN_LONG:  return 5'd20;
            default:   return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/gig_ext_sync.sv
module gig_ext_sync (
    input  logic clk,
    input  logic rst,
    input  logic ext_gate,
    input  logic ext_en,
    output logic ext_fall
);
    logic [1:0] sync_q;
    logic       prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b00;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], ext_gate};
            prev_q <= sync_q[1];
        end
    end

    assign ext_fall = ext_en & prev_q & ~sync_q[1];
endmodule

// File: rtl/gig_interval_timer.sv
module gig_interval_timer
    import gig_pkg::*;
#(
    parameter int UNIT_TICKS = 400000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     ref_tick,
    input  win_len_e short_len,
    input  win_len_e long_len,
    output win_evt_t evt
);
    localparam int CW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
    localparam logic [CW-1:0] TICK_LAST = CW'(UNIT_TICKS - 1);

    logic [CW-1:0]     tick_cnt;
    logic [UNIT_W-1:0] s_cnt, l_cnt;
    logic [UNIT_W-1:0] s_units, l_units;
    logic              unit_pulse, s_hit, l_hit;

    assign s_units    = short_units(short_len);
    assign l_units    = long_units(long_len);
    assign unit_pulse = run & ref_tick & (tick_cnt == TICK_LAST);
    assign s_hit      = unit_pulse & (s_units != '0) & (s_cnt >= s_units - 5'd1);
    assign l_hit      = unit_pulse & (l_units != '0) & (l_cnt >= l_units - 5'd1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tick_cnt <= '0;
            s_cnt    <= '0;
            l_cnt    <= '0;
        end else if (ref_tick) begin
            tick_cnt <= unit_pulse ? '0 : tick_cnt + 1'b1;
            if (unit_pulse) begin
                s_cnt <= s_hit ? '0 : s_cnt + 5'd1;
                l_cnt <= l_hit ? '0 : l_cnt + 5'd1;
            end
        end
    end

    assign evt.short_end = s_hit;
    assign evt.long_end  = l_hit;

    AST_LONG_ON_SHORT: assert property (@(posedge clk) disable iff (rst)
        (evt.long_end && s_units != '0) |-> evt.short_end); // R11
    AST_HELD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run |=> (s_cnt == '0 && l_cnt == '0)); // R4
endmodule

// File: rtl/gig_strobe_gen.sv
module gig_strobe_gen
    import gig_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  win_evt_t evt,
    input  logic     ext_fall,
    input  logic     clr_on_short,
    input  logic     clr_on_long,
    output strobe_t  stb
);
    logic clr_pend_q;
    logic want_clr;

    assign want_clr = (evt.short_end & clr_on_short)
                    | (evt.long_end  & clr_on_long)
                    | (ext_fall & (clr_on_short | clr_on_long));

    always_ff @(posedge clk) begin
        if (rst) begin
            stb        <= '0;
            clr_pend_q <= 1'b0;
        end else begin
            stb.xfer   <= evt.short_end | evt.long_end | ext_fall;
            clr_pend_q <= want_clr;
            stb.clear  <= clr_pend_q;
        end
    end

    AST_CLEAR_FOLLOWS_XFER: assert property (@(posedge clk) disable iff (rst)
        stb.clear |-> $past(stb.xfer)); // R5
endmodule

// File: rtl/gig_end_flags.sv
module gig_end_flags
    import gig_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  win_evt_t evt,
    input  logic     wr,
    input  logic     wr_short,
    input  logic     wr_long,
    input  logic     ie_short,
    input  logic     ie_long,
    output logic     short_flag,
    output logic     long_flag,
    output logic     irq
);
    logic drop_s, drop_l;

    assign drop_s = wr & ~wr_short;
    assign drop_l = wr & ~wr_long;

    always_ff @(posedge clk) begin
        if (rst) begin
            short_flag <= 1'b0;
            long_flag  <= 1'b0;
        end else begin
            short_flag <= evt.short_end | (short_flag & ~drop_s);
            long_flag  <= evt.long_end  | (long_flag  & ~drop_l);
        end
    end

    assign irq = (short_flag & ie_short) | (long_flag & ie_long);

    AST_SHORT_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (short_flag && !drop_s) |=> short_flag); // R7
    AST_LONG_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        evt.long_end |=> long_flag); // R7
endmodule

// File: rtl/gate_interval_gen.sv
module gate_interval_gen
    import gig_pkg::*;
#(
    parameter int UNIT_TICKS = 400000
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    input  logic ext_gate,
    input  logic en,
    input  logic ext_en,
    input  logic int_en,
    input  logic sel_50ms,
    input  logic sel_100ms,
    input  logic sel_500ms,
    input  logic sel_1s,
    input  logic clr_on_short,
    input  logic clr_on_long,
    input  logic ie_short,
    input  logic ie_long,
    input  logic flag_wr,
    input  logic flag_wr_short,
    input  logic flag_wr_long,
    output logic xfer_stb,
    output logic clear_stb,
    output logic short_flag,
    output logic long_flag,
    output logic irq
);
    win_evt_t evt;
    strobe_t  stb;
    logic     ext_fall;
    logic     run;
    win_len_e short_len, long_len;

    assign run       = en & int_en;
    assign short_len = pick_len(sel_50ms, sel_100ms);
    assign long_len  = pick_len(sel_500ms, sel_1s);

    gig_ext_sync u_ext (
        .clk      (clk),
        .rst      (rst),
        .ext_gate (ext_gate),
        .ext_en   (ext_en),
        .ext_fall (ext_fall)
    );

    gig_interval_timer #(.UNIT_TICKS(UNIT_TICKS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .ref_tick  (ref_tick),
        .short_len (short_len),
        .long_len  (long_len),
        .evt       (evt)
    );

    gig_strobe_gen u_stb (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .ext_fall     (ext_fall),
        .clr_on_short (clr_on_short),
        .clr_on_long  (clr_on_long),
        .stb          (stb)
    );

    gig_end_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .wr         (flag_wr),
        .wr_short   (flag_wr_short),
        .wr_long    (flag_wr_long),
        .ie_short   (ie_short),
        .ie_long    (ie_long),
        .short_flag (short_flag),
        .long_flag  (long_flag),
        .irq        (irq)
    );

    assign xfer_stb  = stb.xfer;
    assign clear_stb = stb.clear;

    AST_NO_SOURCE_NO_XFER: assert property (@(posedge clk) disable iff (rst)
        (!ext_en && !run) |=> !xfer_stb); // R9
endmodule

// File: tb/tb_gate_interval_gen.sv
`timescale 1ns/1ps
module tb_gate_interval_gen;
    logic clk = 0, rst = 1;
    logic ref_tick = 0, ext_gate = 1, en = 0, ext_en = 0, int_en = 0;
    logic sel_50ms = 0, sel_100ms = 0, sel_500ms = 0, sel_1s = 0;
    logic clr_on_short = 0, clr_on_long = 0, ie_short = 0, ie_long = 0;
    logic flag_wr = 0, flag_wr_short = 0, flag_wr_long = 0;
    logic xfer_stb, clear_stb, short_flag, long_flag, irq;

    int checks = 0, fails = 0;
    int nx, nc, first;

    always #2 clk = ~clk;

    gate_interval_gen #(.UNIT_TICKS(4)) dut (.*);

    typedef struct packed {
        logic       ie;
        logic       s50, s100, l500, l1s, cs, cl;
        logic [7:0] n_x, n_c, first;
        logic       sf, lf;
    } vec_t;

    // 4 ticks per unit, ref_tick high every cycle, 82-cycle window
    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd20, 8'd2,  8'd4,  1'b1, 1'b1},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd10, 8'd10, 8'd8,  1'b1, 1'b1},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd10, 8'd0,  8'd8,  1'b1, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd0,  8'd0,  8'd0,  1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd1,  8'd1,  8'd80, 1'b0, 1'b1},
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd0,  8'd0,  8'd0,  1'b0, 1'b0}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic window(input int n);
        nx = 0; nc = 0; first = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (xfer_stb) begin
                nx++;
                if (first == 0) first = i;
            end
            if (clear_stb) nc++;
        end
    endtask

    task automatic drop_flags();
        flag_wr = 1; flag_wr_short = 0; flag_wr_long = 0;
        @(negedge clk);
        flag_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!xfer_stb && !clear_stb && !short_flag && !long_flag && !irq,
              "R1 reset outputs", {xfer_stb, clear_stb, short_flag, long_flag, irq}, 0);

        // table walk: R2 R3 R4 R5 R6 R11
        for (int v = 0; v < 6; v++) begin
            int_en = VECS[v].ie; sel_50ms = VECS[v].s50; sel_100ms = VECS[v].s100;
            sel_500ms = VECS[v].l500; sel_1s = VECS[v].l1s;
            clr_on_short = VECS[v].cs; clr_on_long = VECS[v].cl;
            ref_tick = 1; en = 1;
            window(82);
            check(nx == int'(VECS[v].n_x), $sformatf("R2 R3 R6 xfer count row %0d", v), nx, VECS[v].n_x);
            check(nc == int'(VECS[v].n_c), $sformatf("R5 clear count row %0d", v), nc, VECS[v].n_c);
            check(first == int'(VECS[v].first), $sformatf("R4 first xfer row %0d", v), first, VECS[v].first);
            check(short_flag == VECS[v].sf && long_flag == VECS[v].lf,
                  $sformatf("R7 R11 flags row %0d", v), {short_flag, long_flag}, {VECS[v].sf, VECS[v].lf});
            en = 0;
            @(negedge clk);
            drop_flags();
        end

        // R7 R8: sticky flags, write semantics, interrupt mask
        int_en = 1; sel_50ms = 1; sel_100ms = 0; sel_500ms = 1; sel_1s = 0;
        clr_on_short = 0; clr_on_long = 0; en = 1;
        window(40);
        en = 0;
        repeat (5) @(negedge clk);
        check(short_flag && long_flag, "R7 flags stay set", {short_flag, long_flag}, 3);
        check(!irq, "R8 irq masked", irq, 0);
        ie_short = 1; #1;
        check(irq, "R8 irq short enabled", irq, 1);
        ie_short = 0; ie_long = 1; #1;
        check(irq, "R8 irq long enabled", irq, 1);
        flag_wr = 1; flag_wr_short = 1; flag_wr_long = 1;
        @(negedge clk);
        flag_wr = 0;
        check(short_flag && long_flag, "R7 write one keeps flags", {short_flag, long_flag}, 3);
        flag_wr = 1; flag_wr_short = 1; flag_wr_long = 0;
        @(negedge clk);
        flag_wr = 0;
        check(short_flag && !long_flag, "R7 write zero clears long only", {short_flag, long_flag}, 2);
        check(!irq, "R8 irq drops with flag", irq, 0);
        ie_long = 0;
        drop_flags();
        check(!short_flag && !long_flag, "R7 write zero clears", {short_flag, long_flag}, 0);

        // R10: tick gating
        ref_tick = 0; en = 1;
        window(40);
        check(nx == 0, "R10 no ticks no strobe", nx, 0);
        en = 0;
        @(negedge clk);
        en = 1; ref_tick = 1;
        fork
            window(32);
            for (int i = 0; i < 32; i++) begin
                @(negedge clk); ref_tick = ~ref_tick;
            end
        join
        check(nx == 4, "R10 half-rate count", nx, 4);
        check(first == 7, "R10 half-rate first", first, 7);
        en = 0; ref_tick = 1;
        @(negedge clk);
        drop_flags();

        // R9: external gate
        int_en = 0; ext_en = 1; clr_on_short = 1; clr_on_long = 0;
        ext_gate = 0;
        window(6);
        check(nx == 1 && first == 3, "R9 fall xfer timing", first, 3);
        check(nc == 1, "R9 fall clear", nc, 1);
        ext_gate = 1;
        window(6);
        check(nx == 0, "R9 rising no strobe", nx, 0);
        clr_on_short = 0;
        ext_gate = 0;
        window(6);
        check(nx == 1 && nc == 0, "R9 no clear bits", nc, 0);
        ext_gate = 1;
        window(4);
        ext_en = 0;
        ext_gate = 0;
        window(6);
        check(nx == 0, "R9 disabled ignores edge", nx, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule